// File: doc/BRIEF.md
# Serial Flash Command Front End with Deep Power-Down

This block is the device side of a small serial flash-like memory on an SPI slave link in mode 0. The SPI pins (select active low, serial clock, data in, data out) are sampled by a faster system clock. Bits enter most significant bit first on rising serial clock edges, and data out changes after falling edges. Each transaction begins with an 8-bit instruction. The block answers status, identification and data read instructions. It keeps a write-enable latch. It also has a deep power-down state that is entered and left through two instructions, each followed by a delay counted in system clocks.

Instructions that change state (write enable, power-down, release) take effect only when select rises right after exactly eight bits. When select rises at any other bit count, the request is dropped. While the block is powered down it accepts only the release instruction. During the recovery delay that follows a release it accepts nothing. The data memory is a small computed array. Only the low address bits are decoded, so its contents repeat across the full 24-bit address space.

Top module: `spi_pd_flash`

## Requirements
- R1: After reset the block is in normal operation, the output enable is low, and status reads as 00h.
- R2: Instruction 05h returns the status byte, most significant bit first, repeated for as long as select stays low. Bit 1 of the status byte is the write-enable latch and bit 0 is busy. Each bit is driven after a falling serial clock edge and is valid at the next rising edge.
- R3: Instruction 9Fh returns the three identification bytes 3Ah, 61h, 08h in that order. After the third byte the output enable stays low.
- R4: Instruction 06h sets status bit 1 only if select rises after exactly 8 bits. A rise after 7 or 9 bits leaves the latch unchanged.
- R5: Instruction 03h is followed by a 24-bit address, most significant bit first, during which the output stays disabled. The block then streams the bytes at the address and at each following address, wrapping at MEM_BYTES. The byte at address a is (13*a + 5Ah) mod 256.
- R6: Only the low ADDR_BITS bits of the read address are decoded, so address A reads the same byte as A mod MEM_BYTES.
- R7: Instruction B9h starts power-down entry only when select rises after exactly 8 bits in normal operation. A rise after 7 or 9 bits has no effect.
- R8: Power-down takes effect exactly T_DP clocks after entry starts. During that window, instructions are still served and status bit 0 reads 1.
- R9: While powered down, every instruction other than ABh is ignored: output enable stays low throughout.
- R10: ABh, committed with select rising after exactly 8 bits while powered down, starts a recovery of exactly T_RES clocks. During recovery no instruction is served. Normal operation then resumes. A rise after any other bit count keeps the block powered down.
- R11: The output enable is low whenever select is high and whenever no response byte is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins and counts delays |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block, 0 while not enabled |
| misoOe | output | 1 | High while miso carries a response bit (models the tristate enable) |

## Verification
On every cycle, the checker enforces the following: data out stays disabled while select is high, while powered down and during recovery; power-down entry starts only from normal operation and release only from power-down; and the entry and recovery windows last exactly T_DP and T_RES clocks. The values returned (status bits, identification order, memory bytes, address wraparound and mirroring) only show up in the bench scenarios. The same goes for whether a command was dropped because select rose at the wrong bit count. The bench model tracks the power state and the write-enable latch and predicts every response bit.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;

  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_IDENT   = 8'h9F;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_WAKE    = 8'hAB;

  typedef enum logic [1:0] {
    PWR_NORMAL, PWR_ENTERING, PWR_DOWN, PWR_RELEASING
  } pwrT;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_IGN, CMD_STAT, CMD_ID, CMD_READ, CMD_WREN, CMD_PDN, CMD_REL
  } cmdT;

  typedef enum logic [1:0] {
    SRC_STAT, SRC_ID, SRC_MEM
  } srcT;

  // strobes from control to datapath
  typedef struct packed {
    logic       rxShift;
    logic       txLoad;
    logic       txShift;
    srcT        src;
    logic [1:0] idIdx;
    logic       addrLatch;
    logic       welSet;
    logic       busy;
  } strobeT;

endpackage

// File: rtl/spi_pd_ctrl.sv
module spi_pd_ctrl
  import spi_pd_pkg::*;
#(
  parameter int T_DP  = 100,
  parameter int T_RES = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic [7:0] rxNext,
  output strobeT     stb,
  output pwrT        pwrState,
  output logic       misoOe
);

  localparam int TMAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int TW   = $clog2(TMAX + 1);

  logic          sclkQ, csQ;
  logic [2:0]    bitCnt, byteCnt;
  cmdT           cmd;
  pwrT           pwr;
  logic [TW-1:0] timer;
  logic          resp;
  logic          want;
  srcT           src;
  logic [1:0]    idIdx;

  wire sclkRise   = sclk & ~sclkQ & ~csN;
  wire sclkFall   = ~sclk & sclkQ & ~csN;
  wire csRise     = csN & ~csQ;
  wire byteDone   = sclkRise && (bitCnt == 3'd7);
  wire onBoundary = (bitCnt == 3'd0) && (byteCnt == 3'd1);
  wire outSlot    = sclkFall && (bitCnt == 3'd0) && (byteCnt != 3'd0);

  function automatic cmdT decodeOp(input logic [7:0] op, input pwrT p);
    cmdT c;
    c = CMD_IGN;
    if (p == PWR_NORMAL || p == PWR_ENTERING) begin
      case (op)
        OP_READ:   c = CMD_READ;
        OP_STATUS: c = CMD_STAT;
        OP_WREN:   c = CMD_WREN;
        OP_IDENT:  c = CMD_ID;
        OP_SLEEP:  c = CMD_PDN;
        default:   c = CMD_IGN;
      endcase
    end else if (p == PWR_DOWN && op == OP_WAKE) begin
      c = CMD_REL;
    end
    return c;
  endfunction

  // choose the next response byte at a byte boundary
  always_comb begin
    want  = 1'b0;
    src   = SRC_STAT;
    idIdx = 2'd0;
    if (outSlot) begin
      case (cmd)
        CMD_STAT: want = 1'b1;
        CMD_ID: begin
          src   = SRC_ID;
          idIdx = 2'(byteCnt - 3'd1);
          want  = (byteCnt <= 3'd3);
        end
        CMD_READ: begin
          src  = SRC_MEM;
          want = (byteCnt == 3'd4);
        end
        default: want = 1'b0;
      endcase
    end
  end

  always_comb begin
    stb.rxShift   = sclkRise;
    stb.txLoad    = want;
    stb.txShift   = sclkFall && (bitCnt != 3'd0) && resp;
    stb.src       = src;
    stb.idIdx     = idIdx;
    stb.addrLatch = byteDone && (cmd == CMD_READ) && (byteCnt == 3'd3);
    stb.welSet    = csRise && onBoundary && (cmd == CMD_WREN);
    stb.busy      = (pwr == PWR_ENTERING) || (pwr == PWR_RELEASING);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      csQ     <= 1'b1;
      bitCnt  <= '0;
      byteCnt <= '0;
      cmd     <= CMD_NONE;
      pwr     <= PWR_NORMAL;
      timer   <= '0;
      resp    <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;

      if (csN) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        cmd     <= CMD_NONE;
        resp    <= 1'b0;
      end else begin
        if (sclkRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7 && byteCnt != 3'd4) byteCnt <= byteCnt + 3'd1;
          if (bitCnt == 3'd7 && byteCnt == 3'd0) cmd <= decodeOp(rxNext, pwr);
        end
        if (outSlot) resp <= want;
      end

      // commit on a clean byte boundary
      if (csRise && onBoundary) begin
        if (cmd == CMD_PDN && pwr == PWR_NORMAL) begin
          pwr   <= PWR_ENTERING;
          timer <= TW'(T_DP - 1);
        end else if (cmd == CMD_REL && pwr == PWR_DOWN) begin
          pwr   <= PWR_RELEASING;
          timer <= TW'(T_RES - 1);
        end
      end

      case (pwr)
        PWR_ENTERING: begin
          if (timer == '0) begin
            pwr  <= PWR_DOWN;
            cmd  <= CMD_NONE;
            resp <= 1'b0;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PWR_RELEASING: begin
          if (timer == '0) pwr <= PWR_NORMAL;
          else             timer <= timer - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pwrState = pwr;
  assign misoOe   = resp;

endmodule

// File: rtl/spi_pd_datapath.sv
module spi_pd_datapath
  import spi_pd_pkg::*;
#(
  parameter int          ADDR_BITS = 8,
  parameter logic [23:0] ID_CODE   = 24'h3A6108
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mosi,
  input  strobeT     stb,
  output logic [7:0] rxNext,
  output logic       txBit
);

  logic [7:0]           rxReg;
  logic [ADDR_BITS-1:0] addrSh;
  logic [ADDR_BITS-1:0] addrPtr;
  logic [7:0]           txReg;
  logic                 wel;
  logic [7:0]           loadByte;
  logic [7:0]           idBytes [3];

  // identification bytes, first one sent is the top byte of ID_CODE
  for (genvar g = 0; g < 3; g++) begin : g_id
    assign idBytes[g] = ID_CODE[8*(2-g) +: 8];
  end

  function automatic logic [7:0] memByte(input logic [ADDR_BITS-1:0] a);
    return 8'(32'(a) * 32'd13 + 32'h5A);
  endfunction

  assign rxNext = {rxReg[6:0], mosi};

  always_comb begin
    case (stb.src)
      SRC_ID:  loadByte = (stb.idIdx == 2'd3) ? 8'h00 : idBytes[stb.idIdx];
      SRC_MEM: loadByte = memByte(addrPtr);
      default: loadByte = {6'b0, wel, stb.busy};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      addrSh  <= '0;
      addrPtr <= '0;
      txReg   <= '0;
      wel     <= 1'b0;
    end else begin
      if (stb.rxShift) begin
        rxReg  <= rxNext;
        addrSh <= {addrSh[ADDR_BITS-2:0], mosi};
      end
      if (stb.addrLatch) addrPtr <= {addrSh[ADDR_BITS-2:0], mosi};
      if (stb.welSet) wel <= 1'b1;
      if (stb.txLoad) begin
        txReg <= loadByte;
        if (stb.src == SRC_MEM) addrPtr <= addrPtr + 1'b1;
      end else if (stb.txShift) begin
        txReg <= {txReg[6:0], 1'b0};
      end
    end
  end

  assign txBit = txReg[7];

endmodule

// File: rtl/spi_pd_flash.sv
module spi_pd_flash
  import spi_pd_pkg::*;
#(
  parameter int          ADDR_BITS = 8,
  parameter int          T_DP      = 100,
  parameter int          T_RES     = 150,
  parameter logic [23:0] ID_CODE   = 24'h3A6108
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic misoOe
);

  strobeT     stb;
  pwrT        pwrState;
  logic [7:0] rxNext;
  logic       txBit;

  spi_pd_ctrl #(.T_DP(T_DP), .T_RES(T_RES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .rxNext(rxNext),
    .stb(stb), .pwrState(pwrState), .misoOe(misoOe)
  );

  spi_pd_datapath #(.ADDR_BITS(ADDR_BITS), .ID_CODE(ID_CODE)) uDp (
    .clk(clk), .rstN(rstN), .mosi(mosi), .stb(stb),
    .rxNext(rxNext), .txBit(txBit)
  );

  assign miso = misoOe ? txBit : 1'b0;

endmodule

// File: rtl/spi_pd_flash_chk.sv
module spi_pd_flash_chk
  import spi_pd_pkg::*;
#(
  parameter int T_DP  = 100,
  parameter int T_RES = 150
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic misoOe,
  input pwrT  pwrState
);

  int enterCnt, relCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enterCnt <= 0;
      relCnt   <= 0;
    end else begin
      enterCnt <= (pwrState == PWR_ENTERING)  ? enterCnt + 1 : 0;
      relCnt   <= (pwrState == PWR_RELEASING) ? relCnt + 1 : 0;
    end
  end

  p_quiet_deselected_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !misoOe);

  p_down_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_DOWN) |-> !misoOe);

  p_recovery_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_RELEASING) |-> !misoOe);

  p_entry_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_ENTERING && $past(pwrState) != PWR_ENTERING)
      |-> ($past(pwrState) == PWR_NORMAL && $past(csN)));

  p_release_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_RELEASING && $past(pwrState) != PWR_RELEASING)
      |-> ($past(pwrState) == PWR_DOWN && $past(csN)));

  p_entry_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) == PWR_ENTERING && pwrState != PWR_ENTERING)
      |-> (pwrState == PWR_DOWN && enterCnt == T_DP));

  p_release_length_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) == PWR_RELEASING && pwrState != PWR_RELEASING)
      |-> (pwrState == PWR_NORMAL && relCnt == T_RES));

endmodule

bind spi_pd_flash spi_pd_flash_chk #(.T_DP(T_DP), .T_RES(T_RES)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .misoOe(misoOe), .pwrState(pwrState)
);

// File: tb/sim_spi_pd_flash.sv
`timescale 1ns/1ps
module sim_spi_pd_flash;

  localparam int ADDR_BITS = 8;
  localparam int MEM_BYTES = 1 << ADDR_BITS;
  localparam int T_DP      = 100;
  localparam int T_RES     = 150;
  localparam int H         = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, misoOe;

  int nVec = 0;
  int nFail = 0;
  bit finished = 0;

  // behavioural model state: 0 normal, 1 entering, 2 down, 3 recovering
  int mPwr = 0;
  int mTimer = 0;
  bit mWel = 0;

  always #2 clk = ~clk;

  spi_pd_flash #(.ADDR_BITS(ADDR_BITS), .T_DP(T_DP), .T_RES(T_RES)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoOe(misoOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (mPwr == 1 || mPwr == 3) begin
      if (mTimer == 0) mPwr = (mPwr == 1) ? 2 : 0;
      else mTimer--;
    end
  end

  // every-clock comparison of the output enable
  int csHigh = 0;
  always @(negedge clk) begin
    if (rstN) begin
      csHigh = csN ? csHigh + 1 : 0;
      if (csHigh >= 2) check(misoOe == 1'b0, "R11 deselected", misoOe, 0);
      if (mPwr == 2 || mPwr == 3) check(misoOe == 1'b0, "R9/R10 silent", misoOe, 0);
    end
  end

  function automatic int memAt(input int a);
    return (13 * (a % MEM_BYTES) + 'h5A) % 256;
  endfunction

  task automatic xferBit(input bit b, output bit so, output bit soe);
    mosi = b;
    repeat (H) @(negedge clk);
    so = miso;
    soe = misoOe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  // opBits: bits of the instruction sent (7, 8 or 9 where the 9th is 0)
  task automatic runTxn(input logic [7:0] op, input int opBits, input int nAddr,
                        input logic [23:0] addr, input int nResp, input string req);
    int expQ[$];
    bit so, soe;
    @(negedge clk) csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < opBits; i++) begin
      xferBit((i < 8) ? op[7-i] : 1'b0, so, soe);
      check(soe == 1'b0, req, soe, 0);
    end
    if (opBits >= 8 && (mPwr == 0 || mPwr == 1)) begin
      for (int k = 0; k < nResp; k++) begin
        case (op)
          8'h05: expQ.push_back({mWel, (mPwr == 1 || mPwr == 3)});
          8'h9F: expQ.push_back(k == 0 ? 'h3A : k == 1 ? 'h61 : k == 2 ? 'h08 : -1);
          8'h03: expQ.push_back(memAt(int'(addr) + k));
          default: expQ.push_back(-1);
        endcase
      end
    end else begin
      for (int k = 0; k < nResp; k++) expQ.push_back(-1);
    end
    for (int i = 0; i < nAddr * 8; i++) begin
      xferBit(addr[23-i], so, soe);
      check(soe == 1'b0, req, soe, 0);
    end
    for (int k = 0; k < nResp; k++) begin
      int e = expQ.pop_front();
      for (int b = 7; b >= 0; b--) begin
        xferBit(1'b0, so, soe);
        if (e < 0) check(soe == 1'b0, req, soe, 0);
        else check(soe == 1'b1 && so == e[b], req, {soe, so}, {1'b1, e[b]});
      end
    end
    repeat (H) @(negedge clk);
    csN = 1'b1;
    if (opBits == 8 && nAddr == 0 && nResp == 0) begin
      if (op == 8'h06 && (mPwr == 0 || mPwr == 1)) mWel = 1;
      if (op == 8'hB9 && mPwr == 0) begin mPwr = 1; mTimer = T_DP - 1; end
      if (op == 8'hAB && mPwr == 2) begin mPwr = 3; mTimer = T_RES - 1; end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(misoOe == 1'b0 && miso == 1'b0, "R1 reset outputs", {misoOe, miso}, 0);
    runTxn(8'h05, 8, 0, 24'h0, 2, "R1 R2 status after reset");
    // R3: identification, fourth byte silent
    runTxn(8'h9F, 8, 0, 24'h0, 4, "R3 ident");
    // R4: write enable on wrong bit counts has no effect
    runTxn(8'h06, 7, 0, 24'h0, 0, "R4 wren 7 bits");
    runTxn(8'h06, 9, 0, 24'h0, 0, "R4 wren 9 bits");
    runTxn(8'h05, 8, 0, 24'h0, 1, "R4 latch still clear");
    runTxn(8'h06, 8, 0, 24'h0, 0, "R4 wren");
    runTxn(8'h05, 8, 0, 24'h0, 2, "R4 latch set");
    // R5: reads, sequential and wrapping
    runTxn(8'h03, 8, 3, 24'h000010, 3, "R5 read");
    runTxn(8'h03, 8, 3, 24'h0000FE, 4, "R5 read wrap");
    // R6: mirrored address
    runTxn(8'h03, 8, 3, 24'hABCD10, 2, "R6 mirror");
    // R7: power-down request on wrong bit counts cancelled
    runTxn(8'hB9, 7, 0, 24'h0, 0, "R7 sleep 7 bits");
    runTxn(8'hB9, 9, 0, 24'h0, 0, "R7 sleep 9 bits");
    runTxn(8'h05, 8, 0, 24'h0, 1, "R7 still awake");
    // R8: entry window shows busy and still serves instructions
    runTxn(8'hB9, 8, 0, 24'h0, 0, "R7 sleep");
    runTxn(8'h05, 8, 0, 24'h0, 1, "R8 busy during entry");
    repeat (T_DP + 20) @(negedge clk);
    // R9: powered down, everything but release ignored
    runTxn(8'h05, 8, 0, 24'h0, 2, "R9 status ignored");
    runTxn(8'h9F, 8, 0, 24'h0, 3, "R9 ident ignored");
    runTxn(8'h03, 8, 3, 24'h000010, 1, "R9 read ignored");
    // R10: release on wrong count stays down, then true release
    runTxn(8'hAB, 9, 0, 24'h0, 0, "R10 wake 9 bits");
    runTxn(8'h05, 8, 0, 24'h0, 1, "R10 still down");
    runTxn(8'hAB, 8, 0, 24'h0, 0, "R10 wake");
    runTxn(8'h05, 8, 0, 24'h0, 1, "R10 recovery ignored");
    repeat (T_RES + 20) @(negedge clk);
    runTxn(8'h05, 8, 0, 24'h0, 2, "R10 awake again");
    runTxn(8'h03, 8, 3, 24'h000001, 2, "R10 read after wake");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule